// File: doc/BRIEF.md
# Transceiver Channel Reset Sequencer

This block brings one serial transceiver channel out of reset in a fixed order. It drives four active-high reset lines: one for the transmit PLL, one for the transmit digital logic, one for the receiver analog front end and one for the receiver digital logic. Each reset is released only once the lock condition it depends on has been met. When the last reset is released, a ready flag tells the system that the receiver may carry data.

The same sequence runs at power-up and again after a dynamic reconfiguration of the channel's coding-layer settings. At power-up, the reconfiguration controller holds its busy flag high while it calibrates, and the PLL reset is held until busy falls. After a reconfiguration, a one-cycle done pulse restarts the whole sequence from the PLL reset. In that phase busy only rises for register accesses to the controller, and it is consulted only while the PLL reset is held.

The PLL lock and receiver frequency-lock inputs cross clock domains, so each passes through a two-flop synchronizer. The block's own reset is asserted asynchronously and released on the parallel clock. The lock-to-data wait is a parameter given in parallel-clock cycles.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `arst` is high, and for two rising clock edges after it falls, `pllRst`, `txDigRst`, `rxAnaRst` and `rxDigRst` are 1 and `rxReady` is 0.
- R2: `pllRst` stays 1 while `cfgBusy` is 1 during the initial wait. It falls on the first clock edge at which `cfgBusy` is sampled 0 with the internal reset released.
- R3: `txDigRst` falls three clock edges after `pllLock` rises: two edges of synchronizer and one state update.
- R4: `rxAnaRst` falls exactly five clock cycles after `txDigRst` falls.
- R5: `rxDigRst` falls `LTD_CYCLES` clock cycles after the synchronized frequency lock has started the wait. This is `LTD_CYCLES`+3 edges after `rxFreqLock` rises.
- R6: If the synchronized frequency lock drops during the lock-to-data wait, the wait restarts from zero when lock returns, and `rxDigRst` stays 1 until then.
- R7: `rxReady` is 1 exactly when `rxDigRst` is 0.
- R8: A `cfgDone` pulse sampled at any clock edge reasserts all four resets on that edge. The sequence then restarts from the busy wait of R2.
- R9: When the synchronized PLL lock is 0 after the PLL reset has been released, the next edge reasserts `txDigRst`, `rxAnaRst` and `rxDigRst` while `pllRst` stays 0. The sequence then resumes from R3.
- R10: `cfgBusy` has no effect on any output once `pllRst` has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| arst | input | 1 | Asynchronous block reset, active high |
| cfgBusy | input | 1 | Reconfiguration controller busy flag |
| cfgDone | input | 1 | One-cycle pulse: channel reconfiguration finished |
| pllLock | input | 1 | Transmit PLL lock, asynchronous |
| rxFreqLock | input | 1 | Receiver frequency lock, asynchronous |
| pllRst | output | 1 | Transmit PLL reset, active high |
| txDigRst | output | 1 | Transmit digital reset, active high |
| rxAnaRst | output | 1 | Receiver analog reset, active high |
| rxDigRst | output | 1 | Receiver digital reset, active high |
| rxReady | output | 1 | Receiver ready for data traffic |

## Verification
All outputs decode directly from the state register, so a wrong state shows on the reset pins in the same cycle. The release order becomes wrong, or a line is released early, at the very edge where the fault occurs. A settle or lock-to-data counter that is off by one moves a single release edge by one cycle. The bench catches this because it compares every output against its own model on every cycle. A lost lock or restart pulse that is ignored shows one edge later, as a reset that fails to rise.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  // Fixed settle time after PLL lock before the receiver analog reset may drop.
  localparam int unsigned SETTLE_CYCLES = 5;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // PLL in reset, waiting for controller not busy
    ST_WPLL   = 3'd1,  // PLL running, waiting for lock
    ST_SETTLE = 3'd2,  // tx digital released, settle count running
    ST_WFREQ  = 3'd3,  // rx analog released, waiting for frequency lock
    ST_LTD    = 3'd4,  // lock-to-data count running
    ST_READY  = 3'd5   // all resets released
  } seqState_t;

  typedef struct packed {
    logic settleRun;
    logic ltdRun;
  } seqStrobe_t;
endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/xrs_wait_cnt.sv
module xrs_wait_cnt #(
  parameter int unsigned LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/xrs_datapath.sv
module xrs_datapath
  import xrs_pkg::*;
#(
  parameter int unsigned LTD_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  output logic       settleDone,
  output logic       ltdDone
);
  xrs_wait_cnt #(.LIMIT(SETTLE_CYCLES)) settleCnt_i (
    .clk(clk), .rst(rst), .run(strobe.settleRun), .done(settleDone)
  );

  xrs_wait_cnt #(.LIMIT(LTD_CYCLES)) ltdCnt_i (
    .clk(clk), .rst(rst), .run(strobe.ltdRun), .done(ltdDone)
  );
endmodule

// File: rtl/xrs_ctrl.sv
module xrs_ctrl
  import xrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgBusy,
  input  logic       cfgDone,
  input  logic       pllLockSync,
  input  logic       freqLockSync,
  input  logic       settleDone,
  input  logic       ltdDone,
  output seqStrobe_t strobe,
  output logic       pllRst,
  output logic       txDigRst,
  output logic       rxAnaRst,
  output logic       rxDigRst,
  output logic       rxReady
);
  seqState_t state, stateNext;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    if (cfgDone) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:   if (!cfgBusy) stateNext = ST_WPLL;
        ST_WPLL:   if (pllLockSync) stateNext = ST_SETTLE;
        ST_SETTLE: if (!pllLockSync) stateNext = ST_WPLL;
                   else if (settleDone) stateNext = ST_WFREQ;
        ST_WFREQ:  if (!pllLockSync) stateNext = ST_WPLL;
                   else if (freqLockSync) stateNext = ST_LTD;
        ST_LTD:    if (!pllLockSync) stateNext = ST_WPLL;
                   else if (!freqLockSync) stateNext = ST_WFREQ;
                   else if (ltdDone) stateNext = ST_READY;
        ST_READY:  if (!pllLockSync) stateNext = ST_WPLL;
        default:   stateNext = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.settleRun = (state == ST_SETTLE);
    strobe.ltdRun    = (state == ST_LTD);
    pllRst   = (state == ST_IDLE);
    txDigRst = (state == ST_IDLE) || (state == ST_WPLL);
    rxAnaRst = txDigRst || (state == ST_SETTLE);
    rxDigRst = (state != ST_READY);
    rxReady  = (state == ST_READY);
  end
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
  import xrs_pkg::*;
#(
  parameter int unsigned LTD_CYCLES  = 2500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic cfgBusy,
  input  logic cfgDone,
  input  logic pllLock,
  input  logic rxFreqLock,
  output logic pllRst,
  output logic txDigRst,
  output logic rxAnaRst,
  output logic rxDigRst,
  output logic rxReady
);
  // Block reset: asserted asynchronously, released on the parallel clock.
  logic [1:0] rstPipe;
  logic       rstInt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) rstPipe <= 2'b11;
    else      rstPipe <= {rstPipe[0], 1'b0};
  end
  assign rstInt = rstPipe[1];

  logic       pllLockSync, freqLockSync;
  logic [1:0] lockSync;

  xrs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) lockSync_i (
    .clk(clk), .rst(rstInt), .din({pllLock, rxFreqLock}), .dout(lockSync)
  );
  assign pllLockSync  = lockSync[1];
  assign freqLockSync = lockSync[0];

  seqStrobe_t strobe;
  logic       settleDone, ltdDone;

  xrs_ctrl ctrl_i (
    .clk(clk), .rst(rstInt), .cfgBusy(cfgBusy), .cfgDone(cfgDone),
    .pllLockSync(pllLockSync), .freqLockSync(freqLockSync),
    .settleDone(settleDone), .ltdDone(ltdDone), .strobe(strobe),
    .pllRst(pllRst), .txDigRst(txDigRst), .rxAnaRst(rxAnaRst),
    .rxDigRst(rxDigRst), .rxReady(rxReady)
  );

  xrs_datapath #(.LTD_CYCLES(LTD_CYCLES)) dp_i (
    .clk(clk), .rst(rstInt), .strobe(strobe),
    .settleDone(settleDone), .ltdDone(ltdDone)
  );
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker #(
  parameter int unsigned LTD_CYCLES = 2500
) (
  input logic clk,
  input logic rstInt,
  input logic cfgDone,
  input logic pllLockSync,
  input logic freqLockSync,
  input logic pllRst,
  input logic txDigRst,
  input logic rxAnaRst,
  input logic rxDigRst,
  input logic rxReady
);
  // Consecutive cycles of held frequency lock with the rx analog reset released.
  logic [31:0] lockRun;
  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt)                       lockRun <= '0;
    else if (!freqLockSync || rxAnaRst) lockRun <= '0;
    else if (lockRun < LTD_CYCLES + 2)  lockRun <= lockRun + 1;
  end

  assert_pll_first_R2: assert property (@(posedge clk) disable iff (rstInt)
    !txDigRst |-> !pllRst);

  assert_tx_before_rxana_R4: assert property (@(posedge clk) disable iff (rstInt)
    !rxAnaRst |-> !txDigRst);

  // Settle window is the fixed five-cycle package constant.
  assert_settle_len_R4: assert property (@(posedge clk) disable iff (rstInt)
    $fell(rxAnaRst) |-> !$past(txDigRst, 5));

  assert_rxana_before_rxdig_R5: assert property (@(posedge clk) disable iff (rstInt)
    !rxDigRst |-> !rxAnaRst);

  assert_ltd_wait_R5: assert property (@(posedge clk) disable iff (rstInt)
    $fell(rxDigRst) |-> (lockRun >= LTD_CYCLES));

  assert_ready_match_R7: assert property (@(posedge clk) disable iff (rstInt)
    rxReady == !rxDigRst);

  assert_restart_R8: assert property (@(posedge clk) disable iff (rstInt)
    cfgDone |=> (pllRst && txDigRst && rxAnaRst && rxDigRst));

  assert_lock_loss_R9: assert property (@(posedge clk) disable iff (rstInt)
    !pllLockSync |=> (txDigRst && rxAnaRst && rxDigRst));
endmodule

bind xcvr_rst_seq xrs_checker #(.LTD_CYCLES(LTD_CYCLES)) chk_i (
  .clk(clk), .rstInt(rstInt), .cfgDone(cfgDone),
  .pllLockSync(pllLockSync), .freqLockSync(freqLockSync),
  .pllRst(pllRst), .txDigRst(txDigRst), .rxAnaRst(rxAnaRst),
  .rxDigRst(rxDigRst), .rxReady(rxReady)
);

// File: tb/xcvr_rst_seq_tb.sv
module xcvr_rst_seq_tb_top;
  localparam int LTD = 20;

  logic clk = 1'b0;
  logic arst, cfgBusy, cfgDone, pllLock, rxFreqLock;
  logic pllRst, txDigRst, rxAnaRst, rxDigRst, rxReady;

  always #10 clk = ~clk;  // 50 MHz

  xcvr_rst_seq #(.LTD_CYCLES(LTD)) dut_i (
    .clk(clk), .arst(arst), .cfgBusy(cfgBusy), .cfgDone(cfgDone),
    .pllLock(pllLock), .rxFreqLock(rxFreqLock), .pllRst(pllRst),
    .txDigRst(txDigRst), .rxAnaRst(rxAnaRst), .rxDigRst(rxDigRst),
    .rxReady(rxReady)
  );

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  string scen = "R1";

  // Behavioural reference: phase number, cycles spent in the phase,
  // two-edge delay lines for the lock inputs, reset release countdown.
  int mPhase = 0;
  int mWait = 0;
  int mRstLeft = 2;
  bit mPllQ[$] = '{0, 0};
  bit mFrqQ[$] = '{0, 0};

  always @(posedge clk) begin
    int nxt;
    bit pS, fS;
    if (arst) begin
      mRstLeft = 2; mPhase = 0; mWait = 0;
      mPllQ = '{0, 0}; mFrqQ = '{0, 0};
    end else if (mRstLeft > 0) begin
      mRstLeft--; mPhase = 0; mWait = 0;
      mPllQ = '{0, 0}; mFrqQ = '{0, 0};
    end else begin
      pS = mPllQ[0]; fS = mFrqQ[0];
      nxt = mPhase;
      if (cfgDone) nxt = 0;
      else if (mPhase == 0) begin if (!cfgBusy) nxt = 1; end
      else if (mPhase == 1) begin if (pS) nxt = 2; end
      else if (!pS) nxt = 1;
      else if (mPhase == 2) begin if (mWait == 4) nxt = 3; end
      else if (mPhase == 3) begin if (fS) nxt = 4; end
      else if (mPhase == 4) begin
        if (!fS) nxt = 3;
        else if (mWait == LTD - 1) nxt = 5;
      end
      mWait = (nxt == mPhase) ? mWait + 1 : 0;
      mPhase = nxt;
      void'(mPllQ.pop_front()); mPllQ.push_back(pllLock);
      void'(mFrqQ.pop_front()); mFrqQ.push_back(rxFreqLock);
    end
  end

  task automatic chk(string sig, string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s (%s) %s act=%0b exp=%0b at %0t", req, scen, sig, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("pllRst",   "R2", pllRst,   mPhase == 0);
    chk("txDigRst", "R3", txDigRst, mPhase <= 1);
    chk("rxAnaRst", "R4", rxAnaRst, mPhase <= 2);
    chk("rxDigRst", "R5", rxDigRst, mPhase != 5);
    chk("rxReady",  "R7", rxReady,  mPhase == 5);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired (%s)", scen);
      finishRun();
    end
  end

  initial begin
    arst = 1'b1; cfgBusy = 1'b1; cfgDone = 1'b0; pllLock = 1'b0; rxFreqLock = 1'b0;
    // R1: reset hold and synchronous release
    scen = "R1"; tick(4);
    arst = 1'b0; tick(4);
    // R2: PLL reset held while controller busy
    scen = "R2"; tick(6);
    cfgBusy = 1'b0; tick(3);
    // R3 / R4: PLL lock, then settle
    scen = "R3"; pllLock = 1'b1; tick(4);
    scen = "R4"; tick(6);
    // R5 / R6: frequency lock, dropout during the wait, full wait
    scen = "R5"; rxFreqLock = 1'b1; tick(12);
    scen = "R6"; rxFreqLock = 1'b0; tick(1);
    rxFreqLock = 1'b1; tick(LTD + 8);
    // R7: ready held while locked
    scen = "R7"; tick(3);
    // R10: busy toggled by controller accesses has no effect
    scen = "R10"; cfgBusy = 1'b1; tick(5);
    cfgBusy = 1'b0; tick(3);
    // R9: PLL lock lost after completion, then regained
    scen = "R9"; pllLock = 1'b0; tick(6);
    pllLock = 1'b1; tick(LTD + 15);
    // R8: reconfiguration done restarts, busy briefly high
    scen = "R8"; cfgDone = 1'b1; tick(1);
    cfgDone = 1'b0; cfgBusy = 1'b1; tick(4);
    cfgBusy = 1'b0; tick(LTD + 20);
    // R8: done pulse in the middle of the lock-to-data wait
    rxFreqLock = 1'b0; tick(4);
    rxFreqLock = 1'b1; tick(8);
    cfgDone = 1'b1; tick(1);
    cfgDone = 1'b0; tick(LTD + 20);
    // R1: reset in the middle of operation
    scen = "R1"; arst = 1'b1; tick(3);
    arst = 1'b0; tick(LTD + 20);
    finishRun();
  end
endmodule